// File: doc/BRIEF.md
# NAND Byte Transfer Port

This block sits between a 32-bit register bus and an 8-bit NAND data bus. Software places a word on one of four transmit addresses. The address it picks decides how many bytes of that word go out. The port then drives those bytes onto the data bus, one byte per clock, lowest byte first. In the same cycle as each outgoing byte, the port samples one byte from the data input. Once the last byte has gone out, the sampled bytes form a receive word, and software collects that word from a single receive address.

The port also carries the control around the data path:
- a manual chip-select control;
- a host-enable bit that holds the transfer logic cleared while it is 0;
- a sticky event bit that records a rising edge on the NAND ready/busy line;
- three status registers (raw status, status-enable, signal-enable) that decide what is visible to software and what raises the interrupt line.

A typical sequence is: enable the host, assert chip select, write a word, poll until the transmitter is empty, and read back the captured word.

Top module: `nand_xfer_port`

## Requirements
- R1: A write to 0x18, 0x1C, 0x20 or 0x14 sends 1, 2, 3 or 4 bytes respectively. `nand_dout_vld_o` is high for exactly that many consecutive cycles, starting the cycle after the write.
- R2: Bytes of a transmit word leave on `nand_dout_o` least-significant byte first.
- R3: `nand_din_i` is sampled in every cycle where `nand_dout_vld_o` is high. In the receive word at 0x24, for a transfer of n bytes, the k-th sampled byte (k counted from 0) sits at bits [8*(4-n+k)+7 : 8*(4-n+k)], and the lower 4-n bytes read 0.
- R4: Status bits 0 (transmitter empty) and 1 (transmitter not full) read 1 when idle and 0 while bytes are being sent. Bit 2 (receive word ready) sets when a transfer completes. Bit 3 (receive not full) is its inverse.
- R5: A read of 0x24 pops the receive word, and status bit 2 reads 0 afterwards.
- R6: A rising edge on `nand_rb_i` sets sticky status bit 26. Writing a 1 to bit 26 of 0x04 clears it. Writing 0 leaves it set.
- R7: A read of 0x04 returns the raw status ANDed with the status-enable register at 0x08, which resets to all ones.
- R8: `irq_o` is the OR of raw status AND status-enable AND signal-enable (0x0C). Signal-enable resets to only bit 26 set.
- R9: Bit 0 of 0x10 is the host enable and resets to 0. While it is 0, transmit writes are ignored and an in-flight transfer and the receive word are cleared. Clearing it mid-transfer stops the byte stream after the current byte.
- R10: A transmit write that arrives while a transfer is in progress is ignored.
- R11: In 0x00, bit 1 is manual chip-select enable and bit 0 is chip-select assert, and both read back. `nand_ce_no` is low only while both bits are 1.
- R12: After reset:
  - status reads 0x0000000B;
  - configuration and host enable read 0;
  - `irq_o` is 0 and `nand_ce_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| nand_dout_o | output | 8 | Outgoing data byte |
| nand_dout_vld_o | output | 1 | Outgoing byte valid and sample strobe |
| nand_din_i | input | 8 | Incoming data byte |
| nand_rb_i | input | 1 | Ready/busy line from the NAND device |
| nand_ce_no | output | 1 | Chip select, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a host-enable drop in the middle of a word. The drop must land in the exact cycle after the first byte has left, and the test must then show that no further bytes appear and that no receive word is produced. The bench writes a four-byte word and issues the disable write on the very next bus cycle, expecting exactly one byte on the scoreboard.

A transmit write back-to-back with a running transfer is handled the same way, so that the second write falls while the shifter is busy. The status-enable mask is tested with an event already latched, so that restoring the mask shows whether the event bit survived while it was hidden.

// File: rtl/nxp_pkg.sv
`timescale 1ns/1ps
package nxp_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CFG     = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STS     = 8'h04;
  localparam logic [REG_AW-1:0] OFS_STS_EN  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_SIG_EN  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_HEN     = 8'h10;
  localparam logic [REG_AW-1:0] OFS_TX_BASE = 8'h14;
  localparam logic [REG_AW-1:0] OFS_RX      = 8'h24;

  localparam int unsigned BIT_TX_EMPTY    = 0;
  localparam int unsigned BIT_TX_NOT_FULL = 1;
  localparam int unsigned BIT_RX_READY    = 2;
  localparam int unsigned BIT_RX_NOT_FULL = 3;
  localparam int unsigned BIT_RB_EVT      = 26;

  localparam int unsigned BIT_CS_MAN_EN = 1;
  localparam int unsigned BIT_CS_ASSERT = 0;
endpackage

// File: rtl/nxp_rb_edge.sv
`timescale 1ns/1ps
module nxp_rb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rise_o
);
  logic rb_q;

  // reset high so a line that is already ready gives no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_q <= 1'b1;
    else         rb_q <= rb_i;
  end

  assign rise_o = rb_i & ~rb_q;
endmodule

// File: rtl/nxp_shift.sv
`timescale 1ns/1ps
module nxp_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              pop_i,
  output logic              busy_o,
  output logic [BYTE_W-1:0] dout_o,
  output logic              dout_vld_o,
  input  logic [BYTE_W-1:0] din_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] acc_q;
  logic              rx_valid_q;
  logic [WORD_W-1:0] rx_word_q;
  logic              last_byte;
  logic [WORD_W-1:0] acc_nxt;

  assign last_byte = busy_q && (cnt_q == CNT_W'(1));
  // new byte enters at the top so a short word ends up packed high
  assign acc_nxt   = {din_i, acc_q[WORD_W-1:BYTE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      tx_q       <= '0;
      acc_q      <= '0;
      rx_valid_q <= 1'b0;
      rx_word_q  <= '0;
    end else if (!en_i) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      tx_q       <= '0;
      acc_q      <= '0;
      rx_valid_q <= 1'b0;
      rx_word_q  <= '0;
    end else begin
      if (pop_i) rx_valid_q <= 1'b0;
      if (busy_q) begin
        tx_q  <= tx_q >> BYTE_W;
        acc_q <= acc_nxt;
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_byte) begin
          busy_q     <= 1'b0;
          rx_valid_q <= 1'b1;
          rx_word_q  <= acc_nxt;
        end
      end else if (load_i && (load_cnt_i != '0)) begin
        busy_q <= 1'b1;
        cnt_q  <= load_cnt_i;
        tx_q   <= load_word_i;
        acc_q  <= '0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign dout_o     = tx_q[BYTE_W-1:0];
  assign dout_vld_o = busy_q & en_i;
  assign rx_valid_o = rx_valid_q;
  assign rx_word_o  = rx_word_q;

  AST_LAST_BYTE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_byte && en_i) |=> (!busy_o && rx_valid_o)); // R4
  AST_POP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !busy_q && en_i) |=> !rx_valid_o); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !rx_valid_o)); // R9
  AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_byte && en_i && load_i) |=> (busy_o && cnt_q == $past(cnt_q) - CNT_W'(1))); // R10
endmodule

// File: rtl/nxp_regs.sv
`timescale 1ns/1ps
module nxp_regs
  import nxp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned IDX_W = REG_AW - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              rb_rise_i,
  input  logic              tx_busy_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              hen_o,
  output logic              ce_n_o,
  output logic              tx_load_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic              rx_pop_o,
  output logic              irq_o
);
  logic              wr, rd;
  logic [1:0]        cfg_q;
  logic              hen_q;
  logic              rb_evt_q;
  logic [WORD_W-1:0] sts_en_q, sig_en_q, raw_sts;
  logic [REG_AW-1:0] tx_off;
  logic [IDX_W-1:0]  tx_idx;
  logic              tx_hit;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  assign tx_off = bus_addr_i - OFS_TX_BASE;
  assign tx_idx = tx_off[REG_AW-1:2];
  assign tx_hit = (bus_addr_i >= OFS_TX_BASE) && (tx_off[1:0] == 2'b00)
                  && (tx_idx < IDX_W'(LANES));
  // the first address carries a full word, the next ones 1..LANES-1 bytes
  assign tx_cnt_o  = (tx_idx == '0) ? CNT_W'(LANES) : CNT_W'(tx_idx);
  assign tx_load_o = wr & tx_hit;
  assign rx_pop_o  = rd && (bus_addr_i == OFS_RX);

  always_comb begin
    raw_sts                  = '0;
    raw_sts[BIT_TX_EMPTY]    = ~tx_busy_i;
    raw_sts[BIT_TX_NOT_FULL] = ~tx_busy_i;
    raw_sts[BIT_RX_READY]    = rx_valid_i;
    raw_sts[BIT_RX_NOT_FULL] = ~rx_valid_i;
    raw_sts[BIT_RB_EVT]      = rb_evt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      hen_q    <= 1'b0;
      sts_en_q <= '1;
      sig_en_q <= WORD_W'(1) << BIT_RB_EVT;
    end else if (wr) begin
      unique case (bus_addr_i)
        OFS_CFG:    cfg_q    <= {bus_wdata_i[BIT_CS_MAN_EN], bus_wdata_i[BIT_CS_ASSERT]};
        OFS_HEN:    hen_q    <= bus_wdata_i[0];
        OFS_STS_EN: sts_en_q <= bus_wdata_i;
        OFS_SIG_EN: sig_en_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  // set has priority over a same-cycle clear so no edge is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rb_evt_q <= 1'b0;
    else if (rb_rise_i)         rb_evt_q <= 1'b1;
    else if (wr && bus_addr_i == OFS_STS && bus_wdata_i[BIT_RB_EVT])
                                rb_evt_q <= 1'b0;
  end

  always_comb begin
    unique case (bus_addr_i)
      OFS_CFG:    bus_rdata_o = WORD_W'(cfg_q);
      OFS_STS:    bus_rdata_o = raw_sts & sts_en_q;
      OFS_STS_EN: bus_rdata_o = sts_en_q;
      OFS_SIG_EN: bus_rdata_o = sig_en_q;
      OFS_HEN:    bus_rdata_o = WORD_W'(hen_q);
      OFS_RX:     bus_rdata_o = rx_word_i;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign hen_o  = hen_q;
  assign ce_n_o = ~(cfg_q[1] & cfg_q[0]);
  assign irq_o  = |(raw_sts & sts_en_q & sig_en_q);

  AST_RB_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_rise_i |=> bus_rdata_o[BIT_RB_EVT] || !sts_en_q[BIT_RB_EVT] || bus_addr_i != OFS_STS); // R6
  AST_RB_EVT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_evt_q && !(wr && bus_addr_i == OFS_STS && bus_wdata_i[BIT_RB_EVT])) |=> rb_evt_q); // R6
  AST_CS_BOTH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_CFG && bus_wdata_i[1:0] == 2'b11) |=> !ce_n_o); // R11
  AST_CS_ONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_CFG && bus_wdata_i[1:0] != 2'b11) |=> ce_n_o); // R11
endmodule

// File: rtl/nand_xfer_port.sv
`timescale 1ns/1ps
module nand_xfer_port
  import nxp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic [BYTE_W-1:0] nand_dout_o,
  output logic              nand_dout_vld_o,
  input  logic [BYTE_W-1:0] nand_din_i,
  input  logic              nand_rb_i,
  output logic              nand_ce_no,
  output logic              irq_o
);
  logic              rb_rise, hen, tx_load, rx_pop, tx_busy, rx_valid;
  logic [CNT_W-1:0]  tx_cnt;
  logic [WORD_W-1:0] rx_word;

  nxp_rb_edge u_rb_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rb_i   (nand_rb_i),
    .rise_o (rb_rise)
  );

  nxp_regs #(.LANES(LANES), .WORD_W(WORD_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .rb_rise_i   (rb_rise),
    .tx_busy_i   (tx_busy),
    .rx_valid_i  (rx_valid),
    .rx_word_i   (rx_word),
    .hen_o       (hen),
    .ce_n_o      (nand_ce_no),
    .tx_load_o   (tx_load),
    .tx_cnt_o    (tx_cnt),
    .rx_pop_o    (rx_pop),
    .irq_o       (irq_o)
  );

  nxp_shift #(.BYTE_W(BYTE_W), .LANES(LANES)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (hen),
    .load_i      (tx_load),
    .load_cnt_i  (tx_cnt),
    .load_word_i (bus_wdata_i),
    .pop_i       (rx_pop),
    .busy_o      (tx_busy),
    .dout_o      (nand_dout_o),
    .dout_vld_o  (nand_dout_vld_o),
    .din_i       (nand_din_i),
    .rx_valid_o  (rx_valid),
    .rx_word_o   (rx_word)
  );

  AST_TX_WRITE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load && hen && !tx_busy) |=> nand_dout_vld_o); // R1
endmodule

// File: tb/nand_xfer_port_tb_top.sv
`timescale 1ns/1ps
module nand_xfer_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  dout, din;
  logic        dout_vld, rb = 1'b1, ce_n, irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  // loopback through a fixed pattern so expected receive data is known
  assign din = dout ^ 8'hA5;

  nand_xfer_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nand_dout_o(dout), .nand_dout_vld_o(dout_vld), .nand_din_i(din),
    .nand_rb_i(rb), .nand_ce_no(ce_n), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_s, act, exp);
    end
  endtask

  // monitor: every outgoing byte must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && dout_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", {24'h0, dout}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(dout == e, "R2 byte order", {24'h0, dout}, {24'h0, e});
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #0.5;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #0.5;
    req = 1'b0;
  endtask

  task automatic send(input logic [7:0] a, input logic [31:0] w, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(w[8*k +: 8]);
    bus_wr(a, w);
  endtask

  function automatic logic [31:0] exp_rx(input logic [31:0] w, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[8*(4-n+k) +: 8] = w[8*k +: 8] ^ 8'hA5;
    return r;
  endfunction

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  tx_addr [1:4];
    logic [31:0] words   [1:4];
    tx_addr[1] = 8'h18; tx_addr[2] = 8'h1C; tx_addr[3] = 8'h20; tx_addr[4] = 8'h14;
    words[1] = 32'hDEAD_BE5A; words[2] = 32'h0BAD_F00D;
    words[3] = 32'h1234_5678; words[4] = 32'h4433_2211;

    idle(3); rst_n = 1'b1; idle(2);

    // R12 reset state
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R12 status", v, 32'h0000_000B);
    bus_rd(8'h00, v); chk(v == 32'h0, "R12 cfg", v, 32'h0);
    bus_rd(8'h10, v); chk(v == 32'h0, "R12 hen", v, 32'h0);
    chk(irq == 1'b0, "R12 irq", {31'h0, irq}, 32'h0);
    chk(ce_n == 1'b1, "R12 ce", {31'h0, ce_n}, 32'h1);
    bus_rd(8'h0C, v); chk(v == 32'h0400_0000, "R8 sig_en reset", v, 32'h0400_0000);
    bus_rd(8'h08, v); chk(v == 32'hFFFF_FFFF, "R7 sts_en reset", v, 32'hFFFF_FFFF);

    // R9 write while disabled is ignored (monitor flags any byte)
    bus_wr(8'h18, 32'h0000_0077); idle(4);
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R9 ignored when disabled", v, 32'h0000_000B);

    bus_wr(8'h10, 32'h0); bus_wr(8'h10, 32'h1);
    bus_rd(8'h10, v); chk(v == 32'h1, "R9 hen readback", v, 32'h1);

    // R1 R3 R4 R5 each byte count
    for (int n = 4; n >= 1; n--) begin
      send(tx_addr[n], words[n], n);
      if (n == 4) begin
        bus_rd(8'h04, v); chk(v == 32'h0000_0008, "R4 busy flags", v, 32'h8);
      end
      idle(6);
      chk(exp_q.size() == 0, "R1 byte count", exp_q.size(), 0);
      bus_rd(8'h04, v); chk(v == 32'h0000_0007, "R4 done flags", v, 32'h7);
      bus_rd(8'h24, v); chk(v == exp_rx(words[n], n), "R3 rx packing", v, exp_rx(words[n], n));
      bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R5 pop clears", v, 32'hB);
    end

    // R10 second write during transfer is dropped
    send(8'h14, 32'hCAFE_1234, 4);
    bus_wr(8'h18, 32'h0000_0099);
    idle(6);
    chk(exp_q.size() == 0, "R10 first word complete", exp_q.size(), 0);
    bus_rd(8'h24, v); chk(v == exp_rx(32'hCAFE_1234, 4), "R10 rx unchanged", v, exp_rx(32'hCAFE_1234, 4));
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R10 no second transfer", v, 32'hB);

    // R9 abort after first byte
    exp_q.push_back(8'h31);
    bus_wr(8'h14, 32'h3433_3231);
    bus_wr(8'h10, 32'h0);
    idle(6);
    chk(exp_q.size() == 0, "R9 first byte sent", exp_q.size(), 0);
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R9 abort status", v, 32'hB);
    bus_wr(8'h10, 32'h1);
    idle(3);
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R9 no rx after abort", v, 32'hB);

    // R6 R8 ready edge
    @(negedge clk) rb = 1'b0; idle(2);
    @(negedge clk) rb = 1'b1; idle(2);
    bus_rd(8'h04, v); chk(v == 32'h0400_000B, "R6 rb event", v, 32'h0400_000B);
    chk(irq == 1'b1, "R8 irq on event", {31'h0, irq}, 32'h1);
    bus_wr(8'h04, 32'h0); idle(1);
    bus_rd(8'h04, v); chk(v == 32'h0400_000B, "R6 write 0 keeps", v, 32'h0400_000B);
    bus_wr(8'h04, 32'h0400_0000); idle(1);
    bus_rd(8'h04, v); chk(v == 32'h0000_000B, "R6 w1c", v, 32'hB);
    chk(irq == 1'b0, "R8 irq cleared", {31'h0, irq}, 32'h0);

    // R7 R8 status-enable mask
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h04, v); chk(v == 32'h0, "R7 masked status", v, 32'h0);
    @(negedge clk) rb = 1'b0; idle(2);
    @(negedge clk) rb = 1'b1; idle(2);
    chk(irq == 1'b0, "R8 irq masked by sts_en", {31'h0, irq}, 32'h0);
    bus_wr(8'h08, 32'hFFFF_FFFF); idle(1);
    chk(irq == 1'b1, "R8 irq after unmask", {31'h0, irq}, 32'h1);
    bus_wr(8'h04, 32'h0400_0000);
    bus_wr(8'h0C, 32'h0000_0001); idle(1);
    chk(irq == 1'b1, "R8 level bit routed", {31'h0, irq}, 32'h1);
    bus_wr(8'h0C, 32'h0400_0000); idle(1);
    chk(irq == 1'b0, "R8 restore sig_en", {31'h0, irq}, 32'h0);

    // R11 chip select
    bus_wr(8'h00, 32'h1); idle(1);
    chk(ce_n == 1'b1, "R11 assert only", {31'h0, ce_n}, 32'h1);
    bus_wr(8'h00, 32'h2); idle(1);
    chk(ce_n == 1'b1, "R11 enable only", {31'h0, ce_n}, 32'h1);
    bus_wr(8'h00, 32'h3); idle(1);
    chk(ce_n == 1'b0, "R11 both set", {31'h0, ce_n}, 32'h0);
    bus_rd(8'h00, v); chk(v == 32'h3, "R11 readback", v, 32'h3);
    bus_wr(8'h00, 32'h2); idle(1);
    chk(ce_n == 1'b1, "R11 release", {31'h0, ce_n}, 32'h1);

    idle(2);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule